// File: doc/BRIEF.md
# Input-Combination Coverage Histogram

This block watches the three inputs of a single three-input logic gate during a test run. It counts how often each of the eight possible input combinations (minterms) occurs. On every rising clock edge, while counting is enabled, the block takes the present values of the three inputs. By that point in the cycle, combinational transients have settled. The block then adds one to the matching bin. Each bin is a counter that saturates instead of wrapping, so a heavily exercised combination cannot alias back to a small count.

After the run, software or a bench can read any bin through a one-cycle read port. An unused mask marks every combination that never occurred. Such combinations cannot be tested without producing false failures, and they may point to redundant logic. A rank scan lists the rare combinations, so that new test vectors can be aimed at them. On a start strobe, the scan emits the index of every nonzero bin, one index per cycle. The order is by ascending count, and equal counts are broken by the lower index. Zero bins are left out of the list, and a done flag follows the last index.

Top module: `minterm_cov_hist`

## Requirements
- R1: While en_i is high and clr_i is low, each rising edge adds exactly one to bin {c_i,b_i,a_i} (a_i is bit 0, c_i is bit 2) and leaves the other seven bins unchanged.
- R2: A bin is CNT_W bits wide (default 8, or 16 for a larger range). Once it reaches 2^CNT_W-1 it holds that value and never wraps.
- R3: While en_i is low, no bin changes.
- R4: A high clr_i at a rising edge zeroes all eight bins, even when en_i is high in the same cycle. It also cancels a rank scan, so rank_valid_o and rank_done_o are low afterwards.
- R5: rd_data_o shows the count of bin rd_addr_i as it stood at the previous rising edge, which gives one cycle of latency.
- R6: Bit i of unused_o is 1 exactly when bin i holds zero.
- R7: A rank_start_i high at edge E begins a scan. From edge E+1 onward, rank_valid_o is high for one cycle per nonzero bin, with rank_idx_o giving that bin. Bins come in ascending count order, and equal counts come lower index first.
- R8: Zero bins are never emitted. rank_done_o rises one cycle after the last index, or one cycle after the start when every bin is zero. It stays high until the next start or clear, and it is never high together with rank_valid_o.
- R9: Only the input value present at the rising edge is counted. A pulse on an input that starts and ends between two edges leaves its bin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all bins; also cancels a scan |
| en_i | input | 1 | Counting enable |
| a_i | input | 1 | Monitored gate input, index bit 0 |
| b_i | input | 1 | Monitored gate input, index bit 1 |
| c_i | input | 1 | Monitored gate input, index bit 2 |
| rd_addr_i | input | 3 | Bin to read |
| rd_data_o | output | CNT_W | Count of the addressed bin, registered |
| unused_o | output | 8 | Bit i set when bin i is zero |
| rank_start_i | input | 1 | Starts (or restarts) the rank scan |
| rank_valid_o | output | 1 | rank_idx_o holds the next ranked bin |
| rank_idx_o | output | 3 | Index of the bin being emitted |
| rank_done_o | output | 1 | Scan finished |

## Verification
The bench drives one bin past its maximum and checks the count against 255. A design that wraps would show a small number there. A design that merely clamps too late would show one too many. The bench builds equal counts on bins 1 and 6 and checks that the scan emits 3, then 1, then 6. A design that broke ties the wrong way, or that let later equal bins replace earlier ones, would swap 1 and 6. It clears everything and starts a scan, expecting done one cycle later with no valid at all. It also checks that a clear given with counting enabled leaves the bins at zero. Finally, an input pulse that begins and ends between two edges must not be counted. A design that latched inputs on level or on the wrong edge would count that pulse.

// File: rtl/cov_hist_pkg.sv
package cov_hist_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned NBINS = 1 << SEL_W;

  typedef logic [SEL_W-1:0] bin_idx_t;
  typedef logic [NBINS-1:0] bin_mask_t;
endpackage

// File: rtl/cov_bin_bank.sv
module cov_bin_bank #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NBINS = 1 << SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        en_i,
  input  logic [SEL_W-1:0]            sel_i,
  output logic [NBINS-1:0][CNT_W-1:0] cnt_o,
  output logic [NBINS-1:0]            nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < NBINS; g++) begin : g_bin
    logic hit;
    assign hit = en_i && (sel_i == SEL_W'(g)) && (cnt_o[g] != CNT_MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_o[g] <= '0;
      else if (clr_i)   cnt_o[g] <= '0;
      else if (hit)     cnt_o[g] <= cnt_o[g] + 1'b1;
    end

    assign nz_o[g] = |cnt_o[g];
  end
endmodule

// File: rtl/cov_rank_scan.sv
module cov_rank_scan #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 3,
  localparam int unsigned NBINS = 1 << SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        start_i,
  input  logic [NBINS-1:0][CNT_W-1:0] cnt_i,
  input  logic [NBINS-1:0]            nz_i,
  output logic                        valid_o,
  output logic [SEL_W-1:0]            idx_o,
  output logic                        done_o
);
  logic             busy_q;
  logic [NBINS-1:0] taken_q;
  logic [NBINS-1:0] cand;
  logic             found;
  logic [SEL_W-1:0] best_idx;
  logic [CNT_W-1:0] best_cnt;

  assign cand = nz_i & ~taken_q;

  // strict less-than keeps the lowest index among equal counts
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_cnt = '1;
    for (int i = 0; i < NBINS; i++) begin
      if (cand[i] && (!found || cnt_i[i] < best_cnt)) begin
        found    = 1'b1;
        best_idx = SEL_W'(i);
        best_cnt = cnt_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      taken_q <= '0;
      valid_o <= 1'b0;
      idx_o   <= '0;
      done_o  <= 1'b0;
    end else if (clr_i) begin
      busy_q  <= 1'b0;
      taken_q <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      taken_q <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (busy_q) begin
      if (found) begin
        valid_o           <= 1'b1;
        idx_o             <= best_idx;
        taken_q[best_idx] <= 1'b1;
      end else begin
        valid_o <= 1'b0;
        busy_q  <= 1'b0;
        done_o  <= 1'b1;
      end
    end else begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/minterm_cov_hist.sv
module minterm_cov_hist
  import cov_hist_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             c_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [7:0]       unused_o,
  input  logic             rank_start_i,
  output logic             rank_valid_o,
  output logic [2:0]       rank_idx_o,
  output logic             rank_done_o
);
  logic [NBINS-1:0][CNT_W-1:0] cnt_flat;
  bin_mask_t                   nz_mask;
  bin_idx_t                    sel;

  assign sel = {c_i, b_i, a_i};

  cov_bin_bank #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .sel_i  (sel),
    .cnt_o  (cnt_flat),
    .nz_o   (nz_mask)
  );

  cov_rank_scan #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_rank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .start_i (rank_start_i),
    .cnt_i   (cnt_flat),
    .nz_i    (nz_mask),
    .valid_o (rank_valid_o),
    .idx_o   (rank_idx_o),
    .done_o  (rank_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= cnt_flat[rd_addr_i];
  end

  assign unused_o = ~nz_mask;
endmodule

// File: rtl/minterm_cov_hist_chk.sv
module minterm_cov_hist_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  clr_i,
  input logic                  en_i,
  input logic [2:0]            rd_addr_i,
  input logic [CNT_W-1:0]      rd_data_o,
  input logic [7:0]            unused_o,
  input logic                  rank_valid_o,
  input logic [2:0]            rank_idx_o,
  input logic                  rank_done_o,
  input logic [7:0][CNT_W-1:0] cnt_i
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  for (genvar g = 0; g < 8; g++) begin : g_bin
    assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[g] == MAXV && !clr_i) |=> cnt_i[g] == MAXV);
    assert_single_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (CNT_W'(cnt_i[g] - $past(cnt_i[g])) <= CNT_W'(1)));
    assert_hold_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !clr_i) |=> $stable(cnt_i[g]));
  end

  assert_clear_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (unused_o == 8'hFF) && !rank_valid_o && !rank_done_o);

  assert_read_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rd_data_o == $past(cnt_i[rd_addr_i]));

  assert_valid_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rank_valid_o && rank_done_o));

  assert_emit_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_valid_o |-> !unused_o[rank_idx_o]);

  assert_rank_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rank_valid_o && $past(rank_valid_o) && !$past(en_i) && !$past(clr_i)) |->
      ((cnt_i[rank_idx_o] > cnt_i[$past(rank_idx_o)]) ||
       (cnt_i[rank_idx_o] == cnt_i[$past(rank_idx_o)] && rank_idx_o > $past(rank_idx_o))));
endmodule

bind minterm_cov_hist minterm_cov_hist_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .en_i         (en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .unused_o     (unused_o),
  .rank_valid_o (rank_valid_o),
  .rank_idx_o   (rank_idx_o),
  .rank_done_o  (rank_done_o),
  .cnt_i        (cnt_flat)
);

// File: tb/minterm_cov_hist_bench.sv
module minterm_cov_hist_bench;
  localparam int CNT_W = 8;
  localparam int MAXC  = (1 << CNT_W) - 1;
  localparam int NV    = 20;
  // {en, c, b, a}
  localparam logic [3:0] VECS [NV] = '{
    4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1011, 4'b0110, 4'b1101, 4'b1101,
    4'b1101, 4'b0001, 4'b1011, 4'b1000, 4'b1010, 4'b1010, 4'b1010, 4'b0111,
    4'b1001, 4'b1000, 4'b1101, 4'b1011
  };

  logic clk = 0, rst_ni = 0, clr_i = 0, en_i = 0, a_i = 0, b_i = 0, c_i = 0;
  logic [2:0] rd_addr_i = '0;
  logic rank_start_i = 0;
  logic [CNT_W-1:0] rd_data_o;
  logic [7:0] unused_o;
  logic rank_valid_o, rank_done_o;
  logic [2:0] rank_idx_o;

  int n_tests = 0, n_fail = 0;
  int expc [8];
  bit finished = 0;

  always #4 clk = ~clk;

  minterm_cov_hist #(.CNT_W(CNT_W)) u_minterm_cov_hist (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .en_i(en_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .unused_o(unused_o), .rank_start_i(rank_start_i),
    .rank_valid_o(rank_valid_o), .rank_idx_o(rank_idx_o), .rank_done_o(rank_done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input bit en, input int idx);
    @(negedge clk);
    en_i = en; {c_i, b_i, a_i} = 3'(idx);
    if (en && expc[idx] < MAXC) expc[idx]++;
  endtask

  task automatic idle();
    @(negedge clk);
    en_i = 0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_i = 1; en_i = 1; {c_i, b_i, a_i} = 3'd4;  // R4: clear wins over count
    @(negedge clk);
    clr_i = 0; en_i = 0;
    for (int i = 0; i < 8; i++) expc[i] = 0;
  endtask

  task automatic check_bins(input string tag);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_addr_i = 3'(i);
      @(negedge clk);
      check(rd_data_o == CNT_W'(expc[i]), {tag, " R5 bin read"}, int'(rd_data_o), expc[i]);
      if (expc[i] == 0) m[i] = 1'b1;
    end
    check(unused_o == m, {tag, " R6 unused mask"}, int'(unused_o), int'(m));
  endtask

  task automatic check_rank(input string tag);
    int order [8];
    int n;
    bit taken [8];
    n = 0;
    for (int i = 0; i < 8; i++) taken[i] = 0;
    for (int k = 0; k < 8; k++) begin
      int best;
      best = -1;
      for (int i = 0; i < 8; i++)
        if (expc[i] > 0 && !taken[i] && (best < 0 || expc[i] < expc[best])) best = i;
      if (best >= 0) begin
        taken[best] = 1; order[n] = best; n++;
      end
    end
    @(negedge clk);
    rank_start_i = 1;
    @(negedge clk);
    rank_start_i = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(rank_valid_o && !rank_done_o, {tag, " R7 valid"}, int'(rank_valid_o), 1);
      check(rank_idx_o == 3'(order[k]), {tag, " R7 order"}, int'(rank_idx_o), order[k]);
    end
    @(negedge clk);
    check(rank_done_o && !rank_valid_o, {tag, " R8 done"}, int'(rank_done_o), 1);
    @(negedge clk);
    check(rank_done_o, {tag, " R8 done held"}, int'(rank_done_o), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) expc[i] = 0;
    #20;
    rst_ni = 1;
    @(negedge clk);
    check(unused_o == 8'hFF, "reset R6 unused", int'(unused_o), 255);
    check(!rank_valid_o && !rank_done_o, "reset R8 rank idle", int'(rank_done_o), 0);
    check(rd_data_o == '0, "reset R5 read", int'(rd_data_o), 0);

    // vector table: R1 counting, R3 disabled entries
    for (int v = 0; v < NV; v++) drive(VECS[v][3], int'(VECS[v][2:0]));
    idle();
    check_bins("table R1 R3");
    check_rank("table");

    // R4: clear with en_i high leaves everything zero
    clear_all();
    check_bins("clear R4");
    check(!rank_done_o, "clear R4 done cancelled", int'(rank_done_o), 0);
    check_rank("all zero R8");

    // R7 ties: bin 6 x2, bin 1 x2, bin 3 x1 -> 3,1,6
    drive(1, 6); drive(1, 1); drive(1, 6); drive(1, 3); drive(1, 1);
    idle();
    check_rank("ties R7");

    // R9: pulse between edges is not counted
    clear_all();
    @(negedge clk);
    en_i = 1; {c_i, b_i, a_i} = 3'd0;
    #1 a_i = 1;
    #1 a_i = 0;
    expc[0] = 1;
    idle();
    check_bins("glitch R9");

    // R2: saturation
    clear_all();
    for (int k = 0; k < MAXC + 45; k++) drive(1, 5);
    idle();
    check_bins("saturate R2");
    check(expc[5] == MAXC, "saturate R2 model", expc[5], MAXC);
    check_rank("saturate");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule